// File: doc/BRIEF.md
# Thermometer Attenuation Controller

This block drives a bank of identical half-decibel attenuation cells from a stored 8-bit control byte and a fast-attack input. The low six bits of the byte set the programmed attenuation in half-decibel units. Codes past the largest legal setting saturate at that setting. The top two bits choose an extra back-off step. That step is added only while the fast-attack input is high. When the input falls, the setting returns to the programmed value.

The cell enables leave the block as a registered thermometer vector. Every change therefore switches one contiguous run of cells in a single clock, and no intermediate pattern appears. The effective cell count is also output. The control byte is loaded by a one-cycle write strobe. The fast-attack input is asynchronous and passes through a synchroniser inside the block.

Top module: `atten_therm_ctrl`

## Requirements
- R1: After reset, `atten_cnt` is 0 and every bit of `therm_en` is 0. The stored control byte is 0x00, so a later high on `fast_atk` gives a count of 4 (2 dB).
- R2: With `fast_atk` low and a stored gain field (bits 5:0) below 40, `atten_cnt` equals the gain field. Each unit is 0.5 dB, and 0 means no attenuation.
- R3: Gain field values from 40 to 63 all give a programmed count of 40 (20 dB).
- R4: While `fast_atk` is high, the step field (bits 7:6) adds to the programmed count: 0 adds 4, 1 adds 8, 2 adds 16 and 3 adds 32. The largest total is 72.
- R5: When `fast_atk` returns low, `atten_cnt` returns to the programmed count.
- R6: Bit i of `therm_en` is 1 exactly when `atten_cnt` is greater than i. The vector is always a thermometer code whose number of ones equals `atten_cnt`.
- R7: A byte presented with `ctrl_we` high is stored at that clock edge. The outputs show its effect after the next clock edge and not before.
- R8: A change on `fast_atk` reaches the outputs on the third rising edge after it is applied: two synchroniser stages, then the output register.
- R9: While `ctrl_we` is low, changes on `ctrl_byte` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_byte | input | 8 | Control byte: bits 7:6 fast-attack step, bits 5:0 gain code |
| fast_atk | input | 1 | Asynchronous fast-attack request |
| therm_en | output | 72 | Thermometer enables for the attenuation cells |
| atten_cnt | output | 7 | Effective attenuation in 0.5 dB cells |

## Verification
The assertions assume `ctrl_we` and `ctrl_byte` are synchronous to `clk`. They also assume that any value of the byte, including the out-of-range gain codes, may arrive. The bench drives every input on the falling edge, so each input is stable a half period before the rising edge that samples it. `fast_atk` is toggled on the falling edge and held for several cycles. This lets the synchroniser delay be counted exactly.

// File: rtl/atc_pkg.sv
package atc_pkg;
   localparam int unsigned ATC_CODE_W  = 6;
   localparam int unsigned ATC_STEP_W  = 2;
   localparam int unsigned ATC_MAX_CODE = 40;
   localparam int unsigned ATC_FA_BASE = 4;

   typedef struct packed {
      logic [ATC_STEP_W-1:0] step_sel;
      logic [ATC_CODE_W-1:0] gain_code;
   } atc_ctrl_t;

   function automatic int unsigned atc_therm_width(input int unsigned max_code,
                                                   input int unsigned fa_base,
                                                   input int unsigned step_w);
      return max_code + (fa_base << ((1 << step_w) - 1));
   endfunction
endpackage

// File: rtl/atc_fa_sync.sv
module atc_fa_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("atc_fa_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/atc_count_calc.sv
module atc_count_calc #(
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned STEP_W   = 2,
   parameter int unsigned MAX_CODE = 40,
   parameter int unsigned FA_BASE  = 4,
   parameter int unsigned CNT_W    = 7
) (
   input  logic [CODE_W-1:0] gain_code,
   input  logic [STEP_W-1:0] step_sel,
   input  logic              fa_active,
   output logic [CNT_W-1:0]  eff_cnt
);
   localparam int unsigned CODE_SPAN = 1 << CODE_W;

   logic [CNT_W-1:0] prog_cnt;
   logic [CNT_W-1:0] fa_cnt;

   generate
      if (MAX_CODE >= CODE_SPAN) begin : g_no_clamp
         always_comb prog_cnt = CNT_W'(gain_code);
      end else begin : g_clamp
         always_comb begin
            if (CNT_W'(gain_code) >= CNT_W'(MAX_CODE)) prog_cnt = CNT_W'(MAX_CODE);
            else                                       prog_cnt = CNT_W'(gain_code);
         end
      end
   endgenerate

   always_comb begin
      fa_cnt = fa_active ? (CNT_W'(FA_BASE) << step_sel) : '0;
      eff_cnt = prog_cnt + fa_cnt;
   end
endmodule

// File: rtl/atc_therm_enc.sv
module atc_therm_enc #(
   parameter int unsigned THERM_W = 72,
   parameter int unsigned CNT_W   = 7
) (
   input  logic [CNT_W-1:0]   cnt,
   output logic [THERM_W-1:0] therm
);
   generate
      for (genvar i = 0; i < THERM_W; i++) begin : g_cell
         assign therm[i] = (cnt > CNT_W'(i));
      end
   endgenerate
endmodule

// File: rtl/atten_therm_ctrl.sv
module atten_therm_ctrl
   import atc_pkg::*;
#(
   parameter int unsigned CODE_W      = ATC_CODE_W,
   parameter int unsigned STEP_W      = ATC_STEP_W,
   parameter int unsigned MAX_CODE    = ATC_MAX_CODE,
   parameter int unsigned FA_BASE     = ATC_FA_BASE,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BYTE_W  = CODE_W + STEP_W,
   localparam int unsigned THERM_W = atc_therm_width(MAX_CODE, FA_BASE, STEP_W),
   localparam int unsigned CNT_W   = $clog2(THERM_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic [BYTE_W-1:0]  ctrl_byte,
   input  logic               fast_atk,
   output logic [THERM_W-1:0] therm_en,
   output logic [CNT_W-1:0]   atten_cnt
);
   localparam logic [CNT_W-1:0] TOP_CNT = CNT_W'(THERM_W);

   generate
      if (MAX_CODE == 0) begin : g_bad_max
         $error("atten_therm_ctrl: MAX_CODE must be nonzero");
      end
      if (FA_BASE == 0) begin : g_bad_base
         $error("atten_therm_ctrl: FA_BASE must be nonzero");
      end
   endgenerate

   logic [BYTE_W-1:0]  ctrl_q;
   logic               fa_s;
   logic [CNT_W-1:0]   next_cnt;
   logic [THERM_W-1:0] next_therm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_byte;
   end

   atc_fa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (fast_atk),
      .sync_out (fa_s)
   );

   atc_count_calc #(
      .CODE_W   (CODE_W),
      .STEP_W   (STEP_W),
      .MAX_CODE (MAX_CODE),
      .FA_BASE  (FA_BASE),
      .CNT_W    (CNT_W)
   ) u_calc (
      .gain_code (ctrl_q[CODE_W-1:0]),
      .step_sel  (ctrl_q[BYTE_W-1:CODE_W]),
      .fa_active (fa_s),
      .eff_cnt   (next_cnt)
   );

   atc_therm_enc #(.THERM_W(THERM_W), .CNT_W(CNT_W)) u_enc (
      .cnt   (next_cnt),
      .therm (next_therm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm_en  <= '0;
         atten_cnt <= '0;
      end else begin
         therm_en  <= next_therm;
         atten_cnt <= next_cnt;
      end
   end

   // R6: output vector is a contiguous run of ones from bit 0
   p_therm_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm_en & (therm_en + THERM_W'(1))) == '0));

   // R6: ones in the vector match the reported count
   p_therm_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(therm_en) == int'(atten_cnt)));

   // R4: total never exceeds the cell bank
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_cnt <= TOP_CNT));

   // R9: stored byte holds without a strobe
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_we |=> $stable(ctrl_q)));

   // R3, R5: with fast attack inactive the count stays within the programmed range
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fa_s |=> (atten_cnt <= CNT_W'(MAX_CODE))));
endmodule

// File: tb/tb_atten_therm_ctrl.sv
`timescale 1ns/1ps
module tb_atten_therm_ctrl;
   localparam int TW = 72;
   localparam int CW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [7:0]    ctrl_byte = 8'h00;
   logic          fast_atk = 1'b0;
   logic [TW-1:0] therm_en;
   logic [CW-1:0] atten_cnt;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   atten_therm_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_byte(ctrl_byte),
      .fast_atk(fast_atk), .therm_en(therm_en), .atten_cnt(atten_cnt)
   );

   function automatic logic [TW-1:0] exp_therm(input int cnt);
      logic [TW-1:0] v = '0;
      for (int i = 0; i < TW; i++) v[i] = (cnt > i);
      return v;
   endfunction

   task automatic check(input string req, input int exp_cnt);
      n_run++;
      if (int'(atten_cnt) != exp_cnt || therm_en != exp_therm(exp_cnt)) begin
         n_fail++;
         $display("FAIL %s: cnt=%0d therm=%h expected cnt=%0d therm=%h",
                  req, atten_cnt, therm_en, exp_cnt, exp_therm(exp_cnt));
      end
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk);
      ctrl_byte = b;
      ctrl_we   = 1'b1;
      @(negedge clk);
      ctrl_we   = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset state", 0);
      fast_atk = 1'b1;
      settle();
      check("R1 default step 2dB", 4);
      fast_atk = 1'b0;
      settle();
   endtask

   task automatic t_prog_range();
      int codes[5] = '{0, 1, 17, 38, 39};
      foreach (codes[k]) begin
         write_byte(8'(codes[k]));
         settle();
         check("R2 programmed code", codes[k]);
      end
   endtask

   task automatic t_clamp();
      int codes[4] = '{40, 41, 50, 63};
      foreach (codes[k]) begin
         write_byte(8'(codes[k]) | 8'hC0);
         settle();
         check("R3 clamp", 40);
      end
   endtask

   task automatic t_fa_steps();
      for (int s = 0; s < 4; s++) begin
         write_byte(8'((s << 6) | 10));
         fast_atk = 1'b1;
         settle();
         check("R4 fast-attack step", 10 + (4 << s));
         fast_atk = 1'b0;
         settle();
         check("R5 release", 10);
      end
      write_byte(8'hFF);
      fast_atk = 1'b1;
      settle();
      check("R4 max total", 72);
      fast_atk = 1'b0;
      settle();
      check("R5 release from max", 40);
   endtask

   task automatic t_ctrl_latency();
      write_byte(8'd5);
      settle();
      write_byte(8'd25);
      check("R7 not yet after store edge", 5);
      @(negedge clk);
      check("R7 visible after next edge", 25);
   endtask

   task automatic t_fa_latency();
      write_byte(8'h40 | 8'd3);
      settle();
      fast_atk = 1'b1;
      @(negedge clk);
      check("R8 edge 1", 3);
      @(negedge clk);
      check("R8 edge 2", 3);
      @(negedge clk);
      check("R8 edge 3", 11);
      fast_atk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8 release edge 2", 11);
      @(negedge clk);
      check("R8 release edge 3", 3);
   endtask

   task automatic t_no_strobe();
      write_byte(8'd12);
      settle();
      @(negedge clk);
      ctrl_byte = 8'hFF;
      settle();
      check("R9 byte ignored without strobe", 12);
      fast_atk = 1'b1;
      settle();
      check("R9 step unchanged without strobe", 16);
      fast_atk = 1'b0;
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_prog_range();
      t_clamp();
      t_fa_steps();
      t_ctrl_latency();
      t_fa_latency();
      t_no_strobe();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule